// File: doc/BRIEF.md
# Memory Attribute Access Policy Unit

This unit sits between a core's address translation and its cache/bus logic and decides how each memory access should be carried out. It uses four storage attribute bits: write-through, cache-inhibit, coherent and guarded. It also uses the kind of access, a speculative flag, a cache-hit indication and the address. From these it produces one registered decision per accepted request. The decision says whether the access goes through the cache or straight to external memory, whether it must be broadcast for coherency, whether a store is also written through, and whether a prefetch is thrown away.

Guarded memory gets special handling. A speculative load to a guarded page may only finish from the cache. If it misses, the unit parks it in a single hold slot and stalls new requests. The parked load is then either issued as a normal load when the core commits it, or discarded on a flush. A prefetch from a guarded area is allowed only inside the cache block of the most recent non-speculative instruction fetch. The coherent attribute never marks instruction traffic as global.

Top module: `mem_attr_policy`

## Requirements
- R1: An access with the cache-inhibit bit set that is neither held nor dropped decides bypass=1 and use_cache=0.
- R2: An access with cache-inhibit clear that is neither held nor dropped decides use_cache=1 and bypass=0. This holds whether it hits or misses.
- R3: A load (kind 1) or store (kind 2) that is neither held nor dropped decides global_snoop equal to the coherent bit.
- R4: An instruction fetch (kind 0) or prefetch (kind 3) never decides global_snoop=1, whatever the coherent bit is.
- R5: A speculative load to a guarded area that misses, or has cache-inhibit set, is held. It decides dec_valid=1 with stall=1 and every other decision bit 0.
- R6: A speculative guarded load that hits with cache-inhibit clear proceeds as a normal load. The guarded bit has no effect on non-speculative loads or on stores and fetches.
- R7: A prefetch with the guarded bit set decides drop=1 (all other bits 0) unless a non-speculative fetch has been accepted since reset and addr>>log2(BLOCK_BYTES) equals that fetch's block. BLOCK_BYTES is 32 by default.
- R8: While a load is held, stall=1 and req_ready=0, and requests offered are not accepted and produce no decision.
- R9: A commit pulse while holding issues the held load one cycle later as a non-speculative load decision with stall=0. A flush pulse discards it with no decision. Flush wins when both arrive together.
- R10: write_through=1 exactly for a store with write-through set and cache-inhibit clear that is neither held nor dropped.
- R11: Decisions are registered: dec_valid pulses for one cycle, one cycle after acceptance. Out of reset all outputs are 0 and req_ready is 1.
- R12: Commit and flush pulses while nothing is held have no effect and produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (hold slot empty) |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 prefetch |
| req_spec | input | 1 | Access is speculative / out of order |
| attr_w | input | 1 | Write-through attribute |
| attr_i | input | 1 | Cache-inhibit attribute |
| attr_m | input | 1 | Coherent attribute |
| attr_g | input | 1 | Guarded attribute |
| cache_hit | input | 1 | Cache lookup hit |
| req_addr | input | ADDR_W | Access address |
| commit | input | 1 | Held load became non-speculative |
| flush | input | 1 | Discard held load |
| dec_valid | output | 1 | Decision valid this cycle |
| use_cache | output | 1 | Service through the cache |
| bypass | output | 1 | Go straight to external memory |
| global_snoop | output | 1 | Broadcast for hardware coherency |
| write_through | output | 1 | Also write the store to external memory |
| stall | output | 1 | Hold slot occupied |
| drop | output | 1 | Prefetch discarded |

## Verification
A corrupted hold slot shows at the ports in the very next cycle. It appears as req_ready and stall disagreeing with the last held load, or as a commit that issues the wrong cache-inhibit/coherent choice. A stale or wrongly updated fetch-block tracker only shows on the next guarded prefetch. That prefetch is dropped when it should pass, or passes when it should drop. The bench therefore places guarded prefetches on both sides of a block boundary right after each fetch and after ignored requests. A decoder fault shows in the first decision that uses the wrong attribute combination, and the sweep reaches every combination.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

    typedef enum logic [1:0] {
        K_FETCH    = 2'd0,
        K_LOAD     = 2'd1,
        K_STORE    = 2'd2,
        K_PREFETCH = 2'd3
    } kind_e;

    typedef struct packed {
        logic use_cache;
        logic bypass;
        logic glob;
        logic wthru;
        logic drop;
    } dec_t;

endpackage

// File: rtl/mattr_decode.sv
module mattr_decode
    import mattr_pkg::*;
(
    input  kind_e kind,
    input  logic  spec,
    input  logic  w,
    input  logic  i,
    input  logic  m,
    input  logic  g,
    input  logic  hit,
    input  logic  pf_in_block,
    output dec_t  dec,
    output logic  hold_req
);
    logic eff_hit;
    logic is_data;
    logic guard_park;
    logic guard_drop;

    always_comb begin
        eff_hit    = hit && !i;
        is_data    = (kind == K_LOAD) || (kind == K_STORE);
        guard_park = (kind == K_LOAD) && spec && g && !eff_hit;
        guard_drop = (kind == K_PREFETCH) && g && !pf_in_block;

        dec      = '0;
        hold_req = 1'b0;
        if (guard_park) begin
            hold_req = 1'b1;
        end else if (guard_drop) begin
            dec.drop = 1'b1;
        end else begin
            dec.use_cache = !i;
            dec.bypass    = i;
            dec.glob      = m && is_data;
            dec.wthru     = (kind == K_STORE) && w && !i;
        end
    end

    always_comb begin
        if (hold_req || dec.drop)
            a_r1_no_route_when_parked: assert (!dec.use_cache && !dec.bypass);
    end

endmodule

// File: rtl/mattr_blk_track.sv
module mattr_blk_track #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_block
);
    localparam int OFS_W = $clog2(BLOCK_BYTES);
    localparam int BLK_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic             vld;
        logic [BLK_W-1:0] blk;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d    = trk_q;
        in_block = trk_q.vld && (addr[ADDR_W-1:OFS_W] == trk_q.blk);
        if (upd) begin
            trk_d.vld = 1'b1;
            trk_d.blk = addr[ADDR_W-1:OFS_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    a_r7_track_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (trk_q.vld && trk_q.blk == $past(addr[ADDR_W-1:OFS_W])));

endmodule

// File: rtl/mem_attr_policy.sv
module mem_attr_policy
    import mattr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_spec,
    input  logic              attr_w,
    input  logic              attr_i,
    input  logic              attr_m,
    input  logic              attr_g,
    input  logic              cache_hit,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              commit,
    input  logic              flush,
    output logic              dec_valid,
    output logic              use_cache,
    output logic              bypass,
    output logic              global_snoop,
    output logic              write_through,
    output logic              stall,
    output logic              drop
);
    typedef struct packed {
        logic dv;
        dec_t dec;
        logic hold;
        logic hold_i;
        logic hold_m;
    } st_t;

    st_t   st_d, st_q;
    kind_e kind_in;
    kind_e dc_kind;
    logic  dc_spec, dc_w, dc_i, dc_m, dc_g, dc_hit;
    dec_t  dc_dec;
    logic  dc_hold;
    logic  accept;
    logic  trk_upd;
    logic  pf_ok;

    assign kind_in = kind_e'(req_kind);
    assign accept  = req_valid && !st_q.hold;
    assign trk_upd = accept && (kind_in == K_FETCH) && !req_spec;

    // decoder sees the parked load as a committed load while holding
    always_comb begin
        if (st_q.hold) begin
            dc_kind = K_LOAD;
            dc_spec = 1'b0;
            dc_w    = 1'b0;
            dc_i    = st_q.hold_i;
            dc_m    = st_q.hold_m;
            dc_g    = 1'b1;
            dc_hit  = 1'b0;
        end else begin
            dc_kind = kind_in;
            dc_spec = req_spec;
            dc_w    = attr_w;
            dc_i    = attr_i;
            dc_m    = attr_m;
            dc_g    = attr_g;
            dc_hit  = cache_hit;
        end
    end

    mattr_blk_track #(
        .ADDR_W      (ADDR_W),
        .BLOCK_BYTES (BLOCK_BYTES)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (trk_upd),
        .addr     (req_addr),
        .in_block (pf_ok)
    );

    mattr_decode u_decode (
        .kind        (dc_kind),
        .spec        (dc_spec),
        .w           (dc_w),
        .i           (dc_i),
        .m           (dc_m),
        .g           (dc_g),
        .hit         (dc_hit),
        .pf_in_block (pf_ok),
        .dec         (dc_dec),
        .hold_req    (dc_hold)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dv  = 1'b0;
        st_d.dec = '0;
        if (st_q.hold) begin
            if (flush) begin
                st_d.hold = 1'b0;
            end else if (commit) begin
                st_d.hold = 1'b0;
                st_d.dv   = 1'b1;
                st_d.dec  = dc_dec;
            end
        end else if (req_valid) begin
            st_d.dv  = 1'b1;
            st_d.dec = dc_dec;
            if (dc_hold) begin
                st_d.hold   = 1'b1;
                st_d.hold_i = attr_i;
                st_d.hold_m = attr_m;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready     = !st_q.hold;
    assign dec_valid     = st_q.dv;
    assign use_cache     = st_q.dec.use_cache;
    assign bypass        = st_q.dec.bypass;
    assign global_snoop  = st_q.dec.glob;
    assign write_through = st_q.dec.wthru;
    assign drop          = st_q.dec.drop;
    assign stall         = st_q.hold;

    a_r1_route_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(use_cache && bypass));

    a_r4_fetch_never_global: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_in == K_FETCH) |=> (dec_valid && !global_snoop));

    a_r5_guarded_miss_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_in == K_LOAD && req_spec && attr_g && !(cache_hit && !attr_i))
        |=> (stall && dec_valid && !bypass && !use_cache));

    a_r7_drop_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && drop) |-> !(use_cache || bypass || global_snoop || write_through));

    a_r8_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !commit && !flush) |=> (stall && !dec_valid));

    a_r9_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && flush) |=> (!stall && !dec_valid));

    a_r10_wthru_cached: assert property (@(posedge clk) disable iff (!rst_n)
        write_through |-> (use_cache && dec_valid));

endmodule

// File: tb/mem_attr_policy_tb.sv
module mem_attr_policy_tb;
    localparam int ADDR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_spec = 0, attr_w = 0, attr_i = 0, attr_m = 0, attr_g = 0;
    logic cache_hit = 0, commit = 0, flush = 0;
    logic [1:0] req_kind = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, dec_valid, use_cache, bypass, global_snoop, write_through, stall, drop;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mem_attr_policy #(.ADDR_W(ADDR_W), .BLOCK_BYTES(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_spec(req_spec), .attr_w(attr_w), .attr_i(attr_i),
        .attr_m(attr_m), .attr_g(attr_g), .cache_hit(cache_hit), .req_addr(req_addr),
        .commit(commit), .flush(flush), .dec_valid(dec_valid), .use_cache(use_cache),
        .bypass(bypass), .global_snoop(global_snoop), .write_through(write_through),
        .stall(stall), .drop(drop)
    );

    // packed observation: {ready, dv, use, byp, glob, wt, stall, drop}
    function automatic logic [7:0] obs();
        return {req_ready, dec_valid, use_cache, bypass, global_snoop, write_through, stall, drop};
    endfunction

    task automatic check(input logic [7:0] exp, input string req);
        checks++;
        if (obs() !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, obs(), exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <100000", cycles);
            finish_run();
        end
    end

    // expected decision for a fresh request, computed from the requirements
    function automatic logic [7:0] model(input int k, input bit sp, input bit w, input bit i,
                                         input bit m, input bit g, input bit h, input bit pf_ok);
        bit held, dr;
        held = (k == 1) && sp && g && !(h && !i);
        dr   = (k == 3) && g && !pf_ok;
        if (held) return 8'b0_1_0000_1_0;
        if (dr)   return 8'b1_1_0000_0_1;
        return {1'b1, 1'b1, !i, i, m && (k == 1 || k == 2), (k == 2) && w && !i, 1'b0, 1'b0};
    endfunction

    task automatic issue(input int k, input bit sp, input bit w, input bit i, input bit m,
                         input bit g, input bit h, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        req_kind = 2'(k); req_spec = sp; attr_w = w; attr_i = i; attr_m = m;
        attr_g = g; cache_hit = h; req_addr = a; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        check(8'b1_0_0000_0_0, req);
    endtask

    int rel = 0;

    initial begin
        repeat (3) @(negedge clk);
        check(8'b1_0_0000_0_0, "R11 reset state");
        rst_n = 1;
        idle_check("R11 idle after reset");

        // R7: tracker empty after reset -> guarded prefetch dropped
        issue(3, 0, 0, 0, 0, 1, 0, 32'h0);
        check(8'b1_1_0000_0_1, "R7 guarded prefetch after reset");
        issue(3, 0, 0, 0, 0, 0, 0, 32'h0);
        check(8'b1_1_1000_0_0, "R7 unguarded prefetch after reset");
        idle_check("R11 single-cycle pulse");

        // R12: commit/flush with empty slot
        @(negedge clk); commit = 1; flush = 1;
        @(negedge clk); commit = 0; flush = 0;
        check(8'b1_0_0000_0_0, "R12 pulses while empty");

        // establish fetch block 0x1000
        issue(0, 0, 0, 0, 1, 0, 0, 32'h1000);
        check(8'b1_1_1000_0_0, "R4 fetch with M set");

        for (int k = 0; k < 4; k++)
        for (int sp = 0; sp < 2; sp++)
        for (int wimg = 0; wimg < 16; wimg++)
        for (int h = 0; h < 2; h++)
        for (int inb = 0; inb < 2; inb++) begin
            bit w, i, m, g;
            logic [ADDR_W-1:0] a;
            logic [7:0] e;
            w = wimg[3]; i = wimg[2]; m = wimg[1]; g = wimg[0];
            a = (k == 0) ? 32'h1008 : (inb != 0 ? 32'h101C : 32'h1020);
            e = model(k, sp[0], w, i, m, g, h[0], (k == 3) ? inb[0] : 1'b0);
            issue(k, sp[0], w, i, m, g, h[0], a);
            check(e, "R1 R2 R3 R5 R6 R7 R10 sweep");
            if (e[1]) begin
                // R8: request offered while holding is ignored
                issue(0, 0, 0, 1, 1, 0, 0, 32'h9000);
                check(8'b0_0_0000_1_0, "R8 request ignored while held");
                @(negedge clk);
                commit = (rel != 1); flush = (rel != 0);
                @(negedge clk);
                commit = 0; flush = 0;
                if (rel == 0)
                    check({1'b1, 1'b1, !i, i, m, 1'b0, 1'b0, 1'b0}, "R9 commit issues held load");
                else
                    check(8'b1_0_0000_0_0, "R9 flush discards (wins over commit)");
                rel = (rel + 1) % 3;
                // tracker must still hold block 0x1000 (ignored fetch did not update)
                issue(3, 0, 0, 0, 0, 1, 0, 32'h1004);
                check(8'b1_1_1000_0_0, "R8 ignored fetch left tracker");
            end
        end

        // R7 boundary and speculative fetch not tracking
        issue(0, 0, 0, 0, 0, 0, 0, 32'h201F);
        check(8'b1_1_1000_0_0, "R7 required fetch");
        issue(3, 0, 0, 0, 0, 1, 0, 32'h2000);
        check(8'b1_1_1000_0_0, "R7 prefetch block start");
        issue(3, 0, 0, 0, 0, 1, 0, 32'h2020);
        check(8'b1_1_0000_0_1, "R7 prefetch past boundary");
        issue(0, 1, 0, 0, 0, 1, 0, 32'h5000);
        check(8'b1_1_1000_0_0, "R6 speculative guarded fetch");
        issue(3, 0, 0, 1, 0, 1, 0, 32'h2010);
        check(8'b1_1_0100_0_0, "R7 spec fetch did not move block");
        idle_check("R11 idle at end");

        finish_run();
    end
endmodule